// File: doc/BRIEF.md
# DMA Register Read-Back Sequencer

This block serves the read side of a byte-wide DMA controller's command port. It watches every byte written to the port and picks out three commands. 0xBB loads a new read mask from the byte that follows it. 0xA7 starts a read sequence. 0xBF asks for the status byte. Each CPU read of the port then returns one byte: either the status byte or the next internal register chosen by the mask. The transfer engine supplies the status, the byte counter and the two port addresses as live inputs.

A mode input selects between two behaviours. In strict mode, restart commands that arrive while a read is still pending are dropped, and a new mask waits for the next accepted 0xA7. In enhanced mode, 0xA7 and 0xBF act at once even part way through a sequence. Loading a mask in enhanced mode also starts a sequence by itself.

Top module: `dmarb_seq`

## Requirements
- R1: After reset the read mask is 0x7F, no sequence or status request is pending, and a read returns the status byte. A read that happens with nothing pending returns the status byte in both modes.
- R2: The byte written right after 0xBB is taken as the mask, using bits 6:0. Mask bit 0 selects status, bit 1 counter low, bit 2 counter high, bit 3 port A address low, bit 4 port A address high, bit 5 port B address low and bit 6 port B address high.
- R3: An accepted 0xA7 points the sequence at the lowest set mask bit. Each read returns the selected byte and moves to the next higher set bit. A read at the highest set bit ends the sequence, and reads after that return status.
- R4: An accepted 0xBF makes the next read return the status byte. That read clears the request.
- R5: Writes of any other byte between 0xA7 and the reads leave the pending sequence and its position unchanged.
- R6: In strict mode, 0xA7 and 0xBF are ignored while a sequence or a status request is pending.
- R7: In enhanced mode, 0xA7 restarts the sequence and 0xBF replaces it with a status request, even part way through a sequence.
- R8: In enhanced mode, loading a mask starts a sequence with that mask. In strict mode it does not, and a 0xA7 is still needed.
- R9: In strict mode, a mask loaded while a sequence is pending does not change that sequence. The new mask is used from the next accepted 0xA7.
- R10: An accepted 0xA7 with an all-zero mask starts no sequence, and reads return the status byte.
- R11: The byte after 0xBB is always a mask byte, even if it equals a command code. For example, 0xBB then 0xA7 gives mask 0x27 and starts nothing in strict mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enhanced | input | 1 | 1 = enhanced behaviour, 0 = strict behaviour |
| wr_en | input | 1 | Port write strobe, one cycle per byte |
| wr_data | input | 8 | Byte written to the port |
| rd_en | input | 1 | Port read strobe, one cycle per byte |
| status_in | input | 8 | Current status byte |
| count_in | input | 16 | Current byte counter |
| addr_a_in | input | 16 | Current port A address |
| addr_b_in | input | 16 | Current port B address |
| rd_data | output | 8 | Read data; valid in the cycle rd_en is high |

## Verification
The assertions check the following on every cycle:
- Read data equals status whenever a status request is pending or nothing is pending.
- The selected register always has its bit set in the latched mask.
- Strict mode never accepts a restart while a read is pending, and enhanced mode always accepts 0xA7.
- An enhanced mask load with a non-zero mask starts a sequence.
- Idle cycles leave the sequence position unchanged.

Only the bench scenarios can show the actual byte order for a given mask and the wrap to status at the end of a sequence. The same holds for the late effect of a mask changed mid-sequence in strict mode and for a command code being swallowed as a mask byte.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NREG    = 7;
  localparam int SEL_W   = $clog2(NREG);

  typedef logic [NREG-1:0]   mask_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic hit;
    sel_t idx;
  } step_t;

  // index of the lowest set bit, zero when none is set
  function automatic sel_t lowest_set(input mask_t m);
    sel_t r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (m[i]) r = sel_t'(i);
    end
    return r;
  endfunction

  // nearest set bit strictly above cur
  function automatic step_t next_above(input mask_t m, input sel_t cur);
    step_t s;
    s.hit = 1'b0;
    s.idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (m[i] && (i > int'(cur))) begin
        s.hit = 1'b1;
        s.idx = sel_t'(i);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/dmarb_cmd_decode.sv
module dmarb_cmd_decode
  import dmarb_pkg::*;
#(
  parameter byte_t CODE_MASK   = 8'hBB,
  parameter byte_t CODE_INIT   = 8'hA7,
  parameter byte_t CODE_STATUS = 8'hBF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wr_data,
  output logic  mask_load,
  output mask_t mask_val,
  output logic  init_cmd,
  output logic  status_cmd
);
  logic expect_mask;
  logic hdr_cmd;

  always_comb begin
    mask_load  = wr_en && expect_mask;
    mask_val   = wr_data[NREG-1:0];
    hdr_cmd    = wr_en && !expect_mask && (wr_data == CODE_MASK);
    init_cmd   = wr_en && !expect_mask && (wr_data == CODE_INIT);
    status_cmd = wr_en && !expect_mask && (wr_data == CODE_STATUS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         expect_mask <= 1'b0;
    else if (hdr_cmd)   expect_mask <= 1'b1;
    else if (mask_load) expect_mask <= 1'b0;
  end
endmodule

// File: rtl/dmarb_rd_seq.sv
module dmarb_rd_seq
  import dmarb_pkg::*;
#(
  parameter mask_t MASK_RESET = 7'h7F
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enhanced,
  input  logic  mask_load,
  input  mask_t mask_val,
  input  logic  init_cmd,
  input  logic  status_cmd,
  input  logic  rd_en,
  output mask_t live_mask,
  output mask_t seq_mask,
  output sel_t  sel,
  output logic  seq_active,
  output logic  status_req,
  output logic  init_accept,
  output logic  status_accept
);
  logic  pending;
  logic  implicit_start;
  logic  start;
  mask_t start_mask;
  step_t step;

  always_comb begin
    pending        = seq_active || status_req;
    init_accept    = init_cmd && (enhanced || !pending);
    status_accept  = status_cmd && (enhanced || !pending);
    implicit_start = mask_load && enhanced;
    start          = init_accept || implicit_start;
    start_mask     = implicit_start ? mask_val : live_mask;
    step           = next_above(seq_mask, sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) live_mask <= MASK_RESET;
    else if (mask_load) live_mask <= mask_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_mask   <= MASK_RESET;
      sel        <= '0;
      seq_active <= 1'b0;
      status_req <= 1'b0;
    end else if (start) begin
      seq_mask   <= start_mask;
      sel        <= lowest_set(start_mask);
      seq_active <= |start_mask;
      status_req <= 1'b0;
    end else if (status_accept) begin
      status_req <= 1'b1;
      seq_active <= 1'b0;
    end else if (rd_en) begin
      if (status_req) begin
        status_req <= 1'b0;
      end else if (seq_active) begin
        if (step.hit) begin
          sel <= step.idx;
        end else begin
          sel        <= lowest_set(seq_mask);
          seq_active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dmarb_byte_mux.sv
module dmarb_byte_mux
  import dmarb_pkg::*;
(
  input  sel_t               sel,
  input  logic               use_seq,
  input  byte_t              status_in,
  input  logic [WORD_W-1:0]  count_in,
  input  logic [WORD_W-1:0]  addr_a_in,
  input  logic [WORD_W-1:0]  addr_b_in,
  output byte_t              rd_byte
);
  localparam int NWORD = (NREG - 1) / 2;

  logic [WORD_W-1:0] words [NWORD];
  byte_t             bank  [NREG];

  assign words[0] = count_in;
  assign words[1] = addr_a_in;
  assign words[2] = addr_b_in;
  assign bank[0]  = status_in;

  for (genvar w = 0; w < NWORD; w++) begin : g_split
    assign bank[1 + 2*w] = words[w][BYTE_W-1:0];
    assign bank[2 + 2*w] = words[w][WORD_W-1:BYTE_W];
  end

  always_comb begin
    rd_byte = status_in;
    if (use_seq && (int'(sel) < NREG)) rd_byte = bank[sel];
  end
endmodule

// File: rtl/dmarb_seq.sv
module dmarb_seq
  import dmarb_pkg::*;
#(
  parameter byte_t CODE_MASK   = 8'hBB,
  parameter byte_t CODE_INIT   = 8'hA7,
  parameter byte_t CODE_STATUS = 8'hBF,
  parameter mask_t MASK_RESET  = 7'h7F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enhanced,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic [7:0]  status_in,
  input  logic [15:0] count_in,
  input  logic [15:0] addr_a_in,
  input  logic [15:0] addr_b_in,
  output logic [7:0]  rd_data
);
  logic  mask_load;
  mask_t mask_val;
  logic  init_cmd;
  logic  status_cmd;
  mask_t live_mask;
  mask_t seq_mask;
  sel_t  sel;
  logic  seq_active;
  logic  status_req;
  logic  init_accept;
  logic  status_accept;
  logic  use_seq;

  dmarb_cmd_decode #(
    .CODE_MASK(CODE_MASK), .CODE_INIT(CODE_INIT), .CODE_STATUS(CODE_STATUS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mask_load(mask_load), .mask_val(mask_val),
    .init_cmd(init_cmd), .status_cmd(status_cmd)
  );

  dmarb_rd_seq #(.MASK_RESET(MASK_RESET)) u_seq (
    .clk(clk), .rst_n(rst_n), .enhanced(enhanced),
    .mask_load(mask_load), .mask_val(mask_val),
    .init_cmd(init_cmd), .status_cmd(status_cmd), .rd_en(rd_en),
    .live_mask(live_mask), .seq_mask(seq_mask), .sel(sel),
    .seq_active(seq_active), .status_req(status_req),
    .init_accept(init_accept), .status_accept(status_accept)
  );

  assign use_seq = seq_active && !status_req;

  dmarb_byte_mux u_mux (
    .sel(sel), .use_seq(use_seq), .status_in(status_in),
    .count_in(count_in), .addr_a_in(addr_a_in), .addr_b_in(addr_b_in),
    .rd_byte(rd_data)
  );
endmodule

// File: rtl/dmarb_seq_chk.sv
module dmarb_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enhanced,
  input logic       rd_en,
  input logic       init_cmd,
  input logic       status_cmd,
  input logic       init_accept,
  input logic       status_accept,
  input logic       mask_load,
  input logic [6:0] mask_val,
  input logic [6:0] live_mask,
  input logic [6:0] seq_mask,
  input logic [2:0] sel,
  input logic       seq_active,
  input logic       status_req,
  input logic [7:0] rd_data,
  input logic [7:0] status_in
);
  assert_idle_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_active && !status_req) |-> (rd_data == status_in));

  assert_sel_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> seq_mask[sel]);

  assert_status_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_req |-> (rd_data == status_in));

  assert_hold_position_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !rd_en && !init_accept && !status_accept && !(enhanced && mask_load))
      |=> (seq_active && $stable(sel)));

  assert_strict_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enhanced && (seq_active || status_req) && (init_cmd || status_cmd))
      |-> (!init_accept && !status_accept));

  assert_enh_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enhanced && init_cmd) |-> init_accept);

  assert_implicit_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enhanced && mask_load && (mask_val != 7'd0)) |=> seq_active);

  assert_zero_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_accept && !(enhanced && mask_load) && (live_mask == 7'd0)) |=> !seq_active);
endmodule

bind dmarb_seq dmarb_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enhanced(enhanced), .rd_en(rd_en),
  .init_cmd(init_cmd), .status_cmd(status_cmd),
  .init_accept(init_accept), .status_accept(status_accept),
  .mask_load(mask_load), .mask_val(mask_val), .live_mask(live_mask),
  .seq_mask(seq_mask), .sel(sel), .seq_active(seq_active),
  .status_req(status_req), .rd_data(rd_data), .status_in(status_in)
);

// File: tb/dmarb_seq_test.sv
module dmarb_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enhanced = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  status_in = 8'h1A;
  logic [15:0] count_in = 16'h3C4D;
  logic [15:0] addr_a_in = 16'h5E6F;
  logic [15:0] addr_b_in = 16'h7182;
  logic [7:0]  rd_data;

  int vectors = 0;
  int miscompares = 0;

  // expected bytes: status 1A, count lo 4D hi 3C, A lo 6F hi 5E, B lo 82 hi 71
  localparam logic [7:0] ST = 8'h1A, CL = 8'h4D, CH = 8'h3C,
                         AL = 8'h6F, AH = 8'h5E, BL = 8'h82, BH = 8'h71;

  always #10 clk = ~clk;

  dmarb_seq uut (
    .clk(clk), .rst_n(rst_n), .enhanced(enhanced), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .status_in(status_in),
    .count_in(count_in), .addr_a_in(addr_a_in), .addr_b_in(addr_b_in),
    .rd_data(rd_data)
  );

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic get(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    #2;
    vectors++;
    if (rd_data !== exp) begin
      miscompares++;
      $display("FAIL %s: read got %h expected %h", tag, rd_data, exp);
    end
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset_R1();
    do_reset();
    get(ST, "R1");
    put(8'hA7);                     // default mask 0x7F gives all seven
    get(ST, "R1"); get(CL, "R1"); get(CH, "R1"); get(AL, "R1");
    get(AH, "R1"); get(BL, "R1"); get(BH, "R3");
    get(ST, "R3");                  // sequence ended
  endtask

  task automatic t_mask_R2();
    put(8'hBB); put(8'h2A);         // counter lo, A lo, B lo
    put(8'hA7);
    get(CL, "R2"); get(AL, "R2"); get(BL, "R3");
    get(ST, "R3");
  endtask

  task automatic t_other_writes_R5();
    put(8'hA7);
    get(CL, "R5");
    put(8'hC3); put(8'h00); put(8'h7D);
    get(AL, "R5"); get(BL, "R5");
    get(ST, "R5");
  endtask

  task automatic t_strict_ignore_R6();
    put(8'hBB); put(8'h7F);
    put(8'hA7);
    get(ST, "R6"); get(CL, "R6");
    put(8'hA7);
    get(CH, "R6");
    put(8'hBF);
    get(AL, "R6");
    get(AH, "R6"); get(BL, "R6"); get(BH, "R6");
    put(8'hBF);                     // idle now, so accepted
    get(ST, "R4");
    get(ST, "R4");
  endtask

  task automatic t_enhanced_R7();
    enhanced = 1'b1;
    put(8'hBB); put(8'h7E);         // implicit start
    get(CL, "R8"); get(CH, "R7");
    put(8'hA7);
    get(CL, "R7");
    put(8'hBF);
    get(ST, "R7");
    get(ST, "R7");                  // sequence replaced, nothing pending
    enhanced = 1'b0;
  endtask

  task automatic t_strict_no_implicit_R8();
    put(8'hBB); put(8'h06);
    get(ST, "R8");
    put(8'hA7);
    get(CL, "R8"); get(CH, "R8");
    get(ST, "R8");
  endtask

  task automatic t_late_mask_R9();
    put(8'hBB); put(8'h18);
    put(8'hA7);
    get(AL, "R9");
    put(8'hBB); put(8'h60);
    get(AH, "R9");
    get(ST, "R9");
    put(8'hA7);
    get(BL, "R9"); get(BH, "R9");
    get(ST, "R9");
  endtask

  task automatic t_zero_mask_R10();
    put(8'hBB); put(8'h00);
    put(8'hA7);
    get(ST, "R10"); get(ST, "R10");
    enhanced = 1'b1;
    put(8'hBB); put(8'h00);
    get(ST, "R10");
    enhanced = 1'b0;
  endtask

  task automatic t_code_as_mask_R11();
    put(8'hBB); put(8'hA7);         // mask 0x27
    get(ST, "R11");
    put(8'hA7);
    get(ST, "R11"); get(CL, "R11"); get(CH, "R11"); get(BL, "R11");
    get(ST, "R11");
  endtask

  task automatic t_live_inputs_R3();
    status_in = 8'hE5;
    addr_b_in = 16'h9C0D;
    put(8'hBB); put(8'h61);         // status, B lo, B hi
    put(8'hA7);
    get(8'hE5, "R3"); get(8'h0D, "R3"); get(8'h9C, "R3");
    status_in = ST;
    addr_b_in = 16'h7182;
  endtask

  initial begin
    t_reset_R1();
    t_mask_R2();
    t_other_writes_R5();
    t_strict_ignore_R6();
    t_enhanced_R7();
    t_strict_no_implicit_R8();
    t_late_mask_R9();
    t_zero_mask_R10();
    t_code_as_mask_R11();
    t_live_inputs_R3();
    do_reset();
    get(ST, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule